// File: doc/BRIEF.md
# PRBS Loopback Verifier with Word Alignment

This block sits on the receive side of a transceiver self-test path. Its input is the parallel word stream that has come back through a loopback. It first searches that stream for a fixed alignment word. The first word after the alignment word seeds a local reference generator. Each word after that is compared with the reference, which advances one step per word.

The block checks exactly one full period of the maximal-length sequence, which is 255 words in 8-bit mode or 1023 words in 10-bit mode, and then raises a done flag. Any mismatch seen while checking sets an error flag that stays set. Only the digital reset clears the flags and starts a new run. `sel_10b` must be held constant between resets.

The controller has four states:
- HUNT: searching for the alignment word.
- SEED: loading the reference generator.
- CHECK: comparing received words.
- DONE: finished.

Its transitions are:
- HUNT→SEED when the alignment word is seen.
- SEED→CHECK unconditionally, one cycle later.
- CHECK→DONE on the last word of the period.
- DONE holds until reset.
- Reset returns the controller to HUNT from any state.

Top module: `prbs_loop_checker`

## Requirements
- R1: While `rst_dig` is high and in the first cycle after it falls, `chk_done` and `chk_err` are 0.
- R2: In HUNT no comparison is made and neither flag can rise. Alignment is detected at a clock edge where, in 8-bit mode (`sel_10b`=0), the low byte of the previous word was 8'h80 and the low byte of the current word is 8'hFF. In 10-bit mode (`sel_10b`=1), alignment is detected when the current word equals 10'h1FF.
- R3: The word after the alignment word seeds the reference. Each later word is compared with the seed advanced by one more step. A step shifts the reference left by one bit and feeds a new bit into bit 0. That new bit is r[7]^r[5]^r[4]^r[3] in 8-bit mode (x^8+x^6+x^5+x^4+1). It is r[9]^r[6] in 10-bit mode (x^10+x^7+1). In 8-bit mode bits 9:8 of `rx_data` are ignored.
- R4: `chk_done` becomes 1 right after the edge that samples the 255th compared word in 8-bit mode or the 1023rd in 10-bit mode. It is 0 before that edge.
- R5: A compared word that differs from the reference sets `chk_err` right after the edge that samples it. `chk_err` then stays 1 until reset.
- R6: Once `chk_done` is 1, no further comparisons are made. Both flags stay unchanged whatever data arrives, including alignment words.
- R7: A mismatch on the final compared word sets `chk_err` in the same cycle that `chk_done` rises.
- R8: Asserting `rst_dig` after a run clears both flags and restarts the hunt for alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rst_dig | input | 1 | Synchronous digital reset, active high; restarts the run |
| sel_10b | input | 1 | 0 selects the 8-bit mode, 1 selects the 10-bit mode |
| rx_data | input | 10 | Received parallel word |
| chk_done | output | 1 | One full sequence period has been checked |
| chk_err | output | 1 | Sticky mismatch flag |

## Verification
A wrong state shows up at the ports in one of three ways.
- Missed or false alignment moves the whole run in time. `chk_done` then rises earlier or later than the word count predicts, and the mismatched phase raises `chk_err` within a word or two of the seed.
- A corrupted reference register or a wrong tap produces a mismatch on the first compared word after the fault.
- A counter fault moves the rise of `chk_done` by the size of the error.

The bench runs a behavioural model of the same run in parallel and compares both flags after every clock. Any divergence is therefore reported in the cycle in which it first appears.

// File: rtl/prbsv_pkg.sv
package prbsv_pkg;
    localparam int WORD_W  = 10;
    localparam int BYTE_W  = 8;
    localparam int DEG_LO  = 8;
    localparam int DEG_HI  = 10;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_SEED  = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } vstate_t;

    // One shift of the reference generator; new bit enters at bit 0.
    function automatic logic [WORD_W-1:0] prbs_step(input logic [WORD_W-1:0] r,
                                                    input logic              wide);
        logic [WORD_W-1:0] n;
        if (wide) begin
            n = {r[WORD_W-2:0], r[9] ^ r[6]};
        end else begin
            n = '0;
            n[BYTE_W-1:0] = {r[BYTE_W-2:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
        end
        return n;
    endfunction
endpackage

// File: rtl/prbsv_align.sv
module prbsv_align #(
    parameter int WORD_W = prbsv_pkg::WORD_W,
    parameter int BYTE_W = prbsv_pkg::BYTE_W,
    parameter logic [2*BYTE_W-1:0] MARK_NARROW = 16'h80FF,
    parameter logic [WORD_W-1:0]   MARK_WIDE   = 10'h1FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic [WORD_W-1:0] din,
    output logic              hit
);
    logic [BYTE_W-1:0] prev_byte;

    always_ff @(posedge clk) begin
        if (rst) prev_byte <= '0;
        else     prev_byte <= din[BYTE_W-1:0];
    end

    always_comb begin
        if (wide) hit = (din == MARK_WIDE);
        else      hit = ({prev_byte, din[BYTE_W-1:0]} == MARK_NARROW);
    end
endmodule

// File: rtl/prbsv_lfsr.sv
module prbsv_lfsr #(
    parameter int WORD_W = prbsv_pkg::WORD_W,
    parameter int BYTE_W = prbsv_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              load,
    input  logic              adv,
    input  logic [WORD_W-1:0] seed,
    output logic [WORD_W-1:0] ref_next
);
    localparam logic [WORD_W-1:0] MASK_NARROW = WORD_W'((1 << BYTE_W) - 1);

    logic [WORD_W-1:0] ref_q;
    logic [WORD_W-1:0] seed_m;

    assign seed_m   = wide ? seed : (seed & MASK_NARROW);
    assign ref_next = prbsv_pkg::prbs_step(ref_q, wide);

    always_ff @(posedge clk) begin
        if (rst)       ref_q <= '0;
        else if (load) ref_q <= seed_m;
        else if (adv)  ref_q <= ref_next;
    end

    // R3: in the narrow mode the reference never grows above the byte
    a_r3_narrow_ref: assert property (@(posedge clk) disable iff (rst)
        (!wide && $past(!wide)) |-> ((ref_q & ~MASK_NARROW) == '0));
endmodule

// File: rtl/prbsv_count.sv
module prbsv_count #(
    parameter int CNT_W = prbsv_pkg::DEG_HI
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic             last
);
    logic [CNT_W-1:0] cnt;

    assign last = inc && (cnt == limit - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc)   cnt <= cnt + CNT_W'(1);
    end

    // R4: the count never runs past one sequence period
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= limit);
endmodule

// File: rtl/prbs_loop_checker.sv
module prbs_loop_checker #(
    parameter int WORD_W = prbsv_pkg::WORD_W,
    parameter int BYTE_W = prbsv_pkg::BYTE_W,
    parameter int DEG_LO = prbsv_pkg::DEG_LO,
    parameter int DEG_HI = prbsv_pkg::DEG_HI
) (
    input  logic              clk,
    input  logic              rst_dig,
    input  logic              sel_10b,
    input  logic [WORD_W-1:0] rx_data,
    output logic              chk_done,
    output logic              chk_err
);
    import prbsv_pkg::*;

    localparam int CNT_W = DEG_HI;
    localparam logic [CNT_W-1:0] PER_LO = CNT_W'((1 << DEG_LO) - 1);
    localparam logic [CNT_W-1:0] PER_HI = CNT_W'((1 << DEG_HI) - 1);
    localparam logic [WORD_W-1:0] MASK_LO = WORD_W'((1 << BYTE_W) - 1);

    vstate_t           state, state_nx;
    logic              hit, last, in_check, in_seed, mism;
    logic [WORD_W-1:0] ref_next, data_m;
    logic [CNT_W-1:0]  limit;

    assign limit    = sel_10b ? PER_HI : PER_LO;
    assign in_check = (state == ST_CHECK);
    assign in_seed  = (state == ST_SEED);
    assign data_m   = sel_10b ? rx_data : (rx_data & MASK_LO);
    assign mism     = in_check && (data_m != ref_next);

    prbsv_align #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_align (
        .clk(clk), .rst(rst_dig), .wide(sel_10b), .din(rx_data), .hit(hit)
    );

    prbsv_lfsr #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lfsr (
        .clk(clk), .rst(rst_dig), .wide(sel_10b), .load(in_seed),
        .adv(in_check), .seed(rx_data), .ref_next(ref_next)
    );

    prbsv_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst_dig), .clr(in_seed), .inc(in_check),
        .limit(limit), .last(last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst_dig) state <= ST_HUNT;
        else         state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (hit) state_nx = ST_SEED;
            ST_SEED:  state_nx = ST_CHECK;
            ST_CHECK: if (last) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_HUNT;
        endcase
    end

    // output flags
    always_ff @(posedge clk) begin
        if (rst_dig) begin
            chk_done <= 1'b0;
            chk_err  <= 1'b0;
        end else begin
            if (mism)             chk_err  <= 1'b1;
            if (in_check && last) chk_done <= 1'b1;
        end
    end

    // R1: one cycle out of reset the run is idle
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst_dig)
        $past(rst_dig) |-> (state == ST_HUNT && !chk_done && !chk_err));
    // R2: nothing is flagged while hunting for alignment
    a_r2_quiet_hunt: assert property (@(posedge clk) disable iff (rst_dig)
        (state == ST_HUNT) |-> (!chk_done && !chk_err));
    // R5: error is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst_dig)
        chk_err |=> chk_err);
    // R6: after completion both flags freeze
    a_r6_done_freeze: assert property (@(posedge clk) disable iff (rst_dig)
        chk_done |=> (chk_done && $stable(chk_err)));
    // R4: done only rises out of the compare state
    a_r4_done_source: assert property (@(posedge clk) disable iff (rst_dig)
        $rose(chk_done) |-> ($past(state) == ST_CHECK && state == ST_DONE));
endmodule

// File: tb/tb_prbs_loop_checker.sv
module tb_prbs_loop_checker;
    logic       clk = 1'b0;
    logic       rst_dig = 1'b1;
    logic       sel_10b = 1'b0;
    logic [9:0] rx_data = '0;
    logic       chk_done, chk_err;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // behavioural model state
    int m_st = 0;       // 0 hunt, 1 seed, 2 check, 3 done
    int m_ref = 0;
    int m_cnt = 0;
    int m_prev = 0;
    bit m_done = 0;
    bit m_err  = 0;

    always #5 clk = ~clk;

    prbs_loop_checker dut (
        .clk(clk), .rst_dig(rst_dig), .sel_10b(sel_10b),
        .rx_data(rx_data), .chk_done(chk_done), .chk_err(chk_err)
    );

    function automatic int step(input int r, input bit wide);
        int fb;
        if (wide) begin
            fb = ((r >> 9) ^ (r >> 6)) & 1;
            return ((r << 1) | fb) & 1023;
        end
        fb = ((r >> 7) ^ (r >> 5) ^ (r >> 4) ^ (r >> 3)) & 1;
        return ((r << 1) | fb) & 255;
    endfunction

    always @(posedge clk) begin
        int cur, e, per;
        cur = sel_10b ? int'(rx_data) : int'(rx_data[7:0]);
        per = sel_10b ? 1023 : 255;
        if (rst_dig) begin
            m_st = 0; m_ref = 0; m_cnt = 0; m_prev = 0; m_done = 0; m_err = 0;
        end else begin
            case (m_st)
                0: if (sel_10b ? (cur == 'h1FF) : (m_prev == 'h80 && cur == 'hFF)) m_st = 1;
                1: begin m_ref = cur; m_cnt = 0; m_st = 2; end
                2: begin
                    e = step(m_ref, sel_10b);
                    if (cur != e) m_err = 1;
                    m_ref = e;
                    m_cnt++;
                    if (m_cnt == per) begin m_st = 3; m_done = 1; end
                end
                default: ;
            endcase
            m_prev = int'(rx_data[7:0]);
        end
    end

    // compare against the model after every edge (R3/R4/R5/R6)
    always @(posedge clk) begin
        #3;
        if (!finished) begin
            total++;
            if (chk_done !== m_done || chk_err !== m_err) begin
                bad++;
                $display("FAIL R3/R4/R5 model t=%0t done=%b err=%b expected done=%b err=%b",
                         $time, chk_done, chk_err, m_done, m_err);
            end
        end
    end

    task automatic send(input int w);
        @(negedge clk);
        rx_data = 10'(w);
    endtask

    task automatic look(input string tag, input bit exp_done, input bit exp_err);
        @(posedge clk);
        #3;
        total++;
        if (chk_done !== exp_done || chk_err !== exp_err) begin
            bad++;
            $display("FAIL %s done=%b err=%b expected done=%b err=%b",
                     tag, chk_done, chk_err, exp_done, exp_err);
        end
    endtask

    task automatic do_reset(input bit wide);
        @(negedge clk);
        rst_dig = 1'b1;
        sel_10b = wide;
        rx_data = '0;
        repeat (3) @(negedge clk);
        rst_dig = 1'b0;
    endtask

    initial begin
        int s;
        // R1 reset state
        do_reset(1'b0);
        look("R1 reset", 0, 0);

        // R2 hunt in 8-bit mode: near-miss patterns, no flags
        for (int i = 0; i < 20; i++) send(16 + i);
        send('hFF); send('h80); send('h7F); send('h80); send('h80); send('h3F);
        look("R2 hunt quiet", 0, 0);
        // align and seed; upper bits junk (R3 ignore bits 9:8)
        send('h80); send('h3FF);
        s = 'h5A;
        send(s | 'h200);
        for (int i = 1; i <= 254; i++) begin
            s = step(s, 0);
            send(s | ((i % 4) << 8));
        end
        look("R4 not yet done at 254", 0, 0);
        s = step(s, 0);
        send(s);
        look("R4 done at 255 / R3 clean", 1, 0);
        // R6 after done: junk and alignment words change nothing
        send('h80); send('hFF); send('h13); send('h00);
        look("R6 frozen", 1, 0);

        // R8 restart, 10-bit mode with injected mismatch
        do_reset(1'b1);
        look("R8 cleared", 0, 0);
        for (int i = 0; i < 10; i++) send('h0F0 + i);
        send('h1FF);
        s = 'h2C7;
        send(s);
        for (int i = 1; i <= 1023; i++) begin
            s = step(s, 1);
            if (i == 500) begin
                send(s ^ 'h200);
                look("R5 err rises", 0, 1);
            end else begin
                send(s);
            end
            if (i == 1022) look("R4 10b not yet done", 0, 1);
        end
        look("R4/R5 done with sticky err", 1, 1);

        // R7 mismatch on final word
        do_reset(1'b0);
        send('h80); send('hFF);
        s = 'h01;
        send(s);
        for (int i = 1; i <= 254; i++) begin
            s = step(s, 0);
            send(s);
        end
        look("R7 clean before last", 0, 0);
        s = step(s, 0);
        send(s ^ 1);
        look("R7 err with done", 1, 1);
        send('h55);
        look("R6 frozen after err", 1, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule